// File: doc/BRIEF.md
# Adjacent Core Register Rendezvous

This block hands a continuation register from a section on one core to the section that was forked for it on the next core. When a send is decoded on the producing core, it is queued here with the physical register tag that holds the value and with the number of the section booked on the neighbour. When the matching receive is decoded on the neighbour, it is queued under the same section number together with the slot it occupies in the neighbour's issue table. Once a section has both a queued send and a queued receive, and the send's source register has been computed, the block issues the send. This passes the physical tag to the receive and wakes it up. No value moves at that point.

The woken receive later reads the value through a dedicated read port into the producing core's register file. Until every receive that was handed a tag has read it, the tag is reported as pinned, so the producing core must not free that physical register. Within one section, sends and receives pair up in program order. For a continuation value the send is always decoded before its receive. The block serves at most one wake-up per cycle.

Back-pressure works as follows. The send and receive inputs are valid/ready streams. An item is taken on a cycle where both valid and ready are high. Ready depends only on the queue of the section named on the input. The wake-up output is also a valid/ready stream. Once it is raised, it holds its content until it is taken.

Top module: `cont_rdv`

## Requirements
- R1: After reset wake_valid is 0, every pinned bit is 0, and push_ready and pop_ready are 1.
- R2: push_ready is 0 exactly when the send queue of the section on push_sect holds DEPTH entries (4 by default). A dequeue in the same cycle does not raise it. An item is taken when push_valid and push_ready are both 1.
- R3: pop_ready follows the same rule for the receive queue of the section on pop_sect.
- R4: wake_valid is 1 in a cycle exactly when some section has a queued send whose src_ready bit (indexed by the send's tag) is 1 and also has a queued receive. Queues are registered, so a wake-up is first possible in the cycle after both items were taken.
- R5: A wake-up carries the oldest queued send tag and the oldest queued receive slot of its section, so pairs within a section match in program order.
- R6: When no wake-up is stalled, the lowest-numbered eligible section is chosen.
- R7: If wake_valid is 1 and wake_ready is 0, the next cycle shows wake_valid 1 with the same section, tag and slot.
- R8: pinned[t] is 1 from the cycle after a wake handshake that carried tag t. It returns to 0 in the cycle after the number of reads of t equals the number of such handshakes.
- R9: In the same cycle, rf_addr equals rd_tag and rd_data equals rf_data.
- R10: A read (rd_valid) is made only to a pinned tag, and therefore no earlier than the cycle after its wake handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Send decoded on the producing core |
| push_ready | output | 1 | Send queue of push_sect has room |
| push_sect | input | SECT_W | Booked section on the next core |
| push_tag | input | TAG_W | Physical register holding the value |
| src_ready | input | NPHYS | Computed bits of the producing core's registers |
| pop_valid | input | 1 | Receive decoded on the next core |
| pop_ready | output | 1 | Receive queue of pop_sect has room |
| pop_sect | input | SECT_W | Section number of the receive |
| pop_slot | input | SLOT_W | Issue-table slot of the receive |
| wake_valid | output | 1 | A send issues to a receive |
| wake_ready | input | 1 | Next core accepts the wake-up |
| wake_sect | output | SECT_W | Section being served |
| wake_tag | output | TAG_W | Physical tag handed to the receive |
| wake_slot | output | SLOT_W | Slot of the receive to mark ready |
| rd_valid | input | 1 | Woken receive reads its value |
| rd_tag | input | TAG_W | Tag being read |
| rd_data | output | DATA_W | Value returned to the receive |
| rf_addr | output | TAG_W | Dedicated register-file read address |
| rf_data | input | DATA_W | Register-file read data |
| pinned | output | NPHYS | Registers that must not be freed |

## Verification
The ready outputs and the wake-up content are combinational on the queue state. A taken send or receive therefore shows in push_ready, pop_ready and wake_valid in the very next cycle. A wake handshake shows in pinned one cycle after its edge, and a read clears the pin one cycle after its edge. The read path has zero latency. The bench drives inputs at the falling edge and samples one time unit later against a model of the queues, the stall hold and the pin counts. It updates that model at the rising edge using only its own expected handshakes, so every output is compared in the cycle it is due.

// File: rtl/rdv_pkg.sv
package rdv_pkg;
  // Hold state of the wake-up picker
  typedef enum logic {
    PICK_FREE = 1'b0,
    PICK_HELD = 1'b1
  } pick_state_e;

  // Default geometry
  localparam int DEF_NSECT = 4;
  localparam int DEF_DEPTH = 4;
  localparam int DEF_NPHYS = 32;
endpackage

// File: rtl/rdv_fifo.sv
module rdv_fifo #(
  parameter int W     = 5,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));

  // R2
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  // R5
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
endmodule

// File: rtl/rdv_pick.sv
module rdv_pick import rdv_pkg::*; #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          ack,
  output logic          grant_valid,
  output logic [IW-1:0] grant_idx
);
  pick_state_e   state_q;
  logic [IW-1:0] held_q;
  logic [IW-1:0] lowest;

  always_comb begin
    lowest = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) lowest = IW'(i);
    end
  end

  assign grant_idx   = (state_q == PICK_HELD) ? held_q : lowest;
  assign grant_valid = |req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PICK_FREE;
      held_q  <= '0;
    end else begin
      state_q <= (grant_valid && !ack) ? PICK_HELD : PICK_FREE;
      held_q  <= grant_idx;
    end
  end

  // R7
  held_still_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PICK_HELD) |-> req[held_q]);
endmodule

// File: rtl/rdv_pin.sv
module rdv_pin #(
  parameter int NPHYS = 32,
  parameter int PIN_W = 3,
  localparam int TAG_W = $clog2(NPHYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [TAG_W-1:0] inc_tag,
  input  logic             dec_en,
  input  logic [TAG_W-1:0] dec_tag,
  output logic [NPHYS-1:0] pinned
);
  for (genvar r = 0; r < NPHYS; r++) begin : g_reg
    logic [PIN_W-1:0] cnt;
    logic inc_hit, dec_hit;
    assign inc_hit = inc_en && (inc_tag == TAG_W'(r));
    assign dec_hit = dec_en && (dec_tag == TAG_W'(r));

    always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else begin
        case ({inc_hit, dec_hit})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end

    assign pinned[r] = (cnt != '0);

    // R8
    pin_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_hit && !dec_hit) |-> (cnt != '1));
    // R10
    pin_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_hit && !inc_hit) |-> (cnt != '0));
  end
endmodule

// File: rtl/cont_rdv.sv
module cont_rdv import rdv_pkg::*; #(
  parameter int NSECT  = DEF_NSECT,
  parameter int DEPTH  = DEF_DEPTH,
  parameter int NPHYS  = DEF_NPHYS,
  parameter int SLOT_W = 4,
  parameter int DATA_W = 32,
  parameter int PIN_W  = 3,
  localparam int SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1,
  localparam int TAG_W  = $clog2(NPHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [SECT_W-1:0] push_sect,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic [NPHYS-1:0]  src_ready,
  input  logic              pop_valid,
  output logic              pop_ready,
  input  logic [SECT_W-1:0] pop_sect,
  input  logic [SLOT_W-1:0] pop_slot,
  output logic              wake_valid,
  input  logic              wake_ready,
  output logic [SECT_W-1:0] wake_sect,
  output logic [TAG_W-1:0]  wake_tag,
  output logic [SLOT_W-1:0] wake_slot,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rf_addr,
  input  logic [DATA_W-1:0] rf_data,
  output logic [NPHYS-1:0]  pinned
);
  logic [TAG_W-1:0]  snd_head [NSECT];
  logic [SLOT_W-1:0] rcv_head [NSECT];
  logic [NSECT-1:0]  snd_empty, snd_full, rcv_empty, rcv_full;
  logic [NSECT-1:0]  eligible, take;
  logic              push_fire, pop_fire, wake_fire;
  logic              pick_valid;
  logic [SECT_W-1:0] pick_idx;

  assign push_ready = !snd_full[push_sect];
  assign pop_ready  = !rcv_full[pop_sect];
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = pop_valid && pop_ready;

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    rdv_fifo #(.W(TAG_W), .DEPTH(DEPTH)) u_snd (
      .clk(clk), .rst_n(rst_n),
      .wr_en(push_fire && (push_sect == SECT_W'(s))),
      .wr_data(push_tag),
      .rd_en(take[s]),
      .rd_data(snd_head[s]),
      .empty(snd_empty[s]),
      .full(snd_full[s])
    );
    rdv_fifo #(.W(SLOT_W), .DEPTH(DEPTH)) u_rcv (
      .clk(clk), .rst_n(rst_n),
      .wr_en(pop_fire && (pop_sect == SECT_W'(s))),
      .wr_data(pop_slot),
      .rd_en(take[s]),
      .rd_data(rcv_head[s]),
      .empty(rcv_empty[s]),
      .full(rcv_full[s])
    );
    assign eligible[s] = !snd_empty[s] && !rcv_empty[s] && src_ready[snd_head[s]];
    assign take[s]     = wake_fire && (pick_idx == SECT_W'(s));
  end

  rdv_pick #(.N(NSECT)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .req(eligible), .ack(wake_ready),
    .grant_valid(pick_valid), .grant_idx(pick_idx)
  );

  assign wake_valid = pick_valid;
  assign wake_sect  = pick_idx;
  assign wake_tag   = snd_head[pick_idx];
  assign wake_slot  = rcv_head[pick_idx];
  assign wake_fire  = wake_valid && wake_ready;

  rdv_pin #(.NPHYS(NPHYS), .PIN_W(PIN_W)) u_pin (
    .clk(clk), .rst_n(rst_n),
    .inc_en(wake_fire), .inc_tag(wake_tag),
    .dec_en(rd_valid), .dec_tag(rd_tag),
    .pinned(pinned)
  );

  assign rf_addr = rd_tag;
  assign rd_data = rf_data;

  // R4
  wake_src_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> src_ready[wake_tag]);
  // R7
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_valid && !wake_ready) |=> (wake_valid && $stable(wake_sect)
      && $stable(wake_tag) && $stable(wake_slot)));
  // R8
  pin_after_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_fire |=> pinned[$past(wake_tag)]);
  // R10
  read_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> pinned[rd_tag]);
endmodule

// File: tb/sim_cont_rdv.sv
module sim_cont_rdv;
  localparam int CLK_P = 10;
  localparam int NS = 4, DEPTH = 4, NPHYS = 32, TW = 5, SW = 2, SLW = 4, DW = 32;

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, pop_valid = 0, wake_ready = 0, rd_valid = 0;
  logic push_ready, pop_ready, wake_valid;
  logic [SW-1:0] push_sect = 0, pop_sect = 0, wake_sect;
  logic [TW-1:0] push_tag = 0, wake_tag, rd_tag = 0, rf_addr;
  logic [SLW-1:0] pop_slot = 0, wake_slot;
  logic [NPHYS-1:0] src_ready = 0, pinned;
  logic [DW-1:0] rd_data, rf_data;

  always #(CLK_P/2) clk = ~clk;
  assign rf_data = ({27'h0, rf_addr} * 32'h0001_9E37) ^ 32'h5A5A_0000;

  cont_rdv u0 (.*);

  int checks = 0, failures = 0;
  int ptq[NS][$];
  int pqq[NS][$];
  int pcnt[NPHYS];
  int pushed[NS], popped[NS];
  int rdq[$];
  bit lk = 0;
  int lk_s = 0;
  logic [NPHYS-1:0] mask = 0;
  bit d_pv, d_ov, d_wr, d_rv;
  int d_ps, d_pt, d_os, d_oslot, d_rt;

  function automatic logic [DW-1:0] rfval(int a);
    return (32'(a) * 32'h0001_9E37) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    bit exp_pr, exp_or, exp_v;
    int exp_s;
    bit [NS-1:0] elig;
    logic [NPHYS-1:0] exp_pin;
    @(negedge clk);
    push_valid = d_pv; push_sect = SW'(d_ps); push_tag = TW'(d_pt);
    pop_valid = d_ov; pop_sect = SW'(d_os); pop_slot = SLW'(d_oslot);
    wake_ready = d_wr; rd_valid = d_rv; rd_tag = TW'(d_rt); src_ready = mask;
    #1;
    exp_pr = ptq[d_ps].size() < DEPTH;
    exp_or = pqq[d_os].size() < DEPTH;
    chk(push_ready == exp_pr, "R2", "push_ready", push_ready, exp_pr);
    chk(pop_ready == exp_or, "R3", "pop_ready", pop_ready, exp_or);
    for (int s = 0; s < NS; s++)
      elig[s] = ptq[s].size() > 0 && pqq[s].size() > 0 && mask[ptq[s][0]];
    exp_v = |elig;
    exp_s = 0;
    for (int s = NS - 1; s >= 0; s--) if (elig[s]) exp_s = s;
    if (lk) exp_s = lk_s;
    chk(wake_valid == exp_v, "R4", "wake_valid", wake_valid, exp_v);
    if (exp_v) begin
      chk(wake_sect == SW'(exp_s), lk ? "R7" : "R6", "wake_sect", wake_sect, exp_s);
      chk(wake_tag == TW'(ptq[exp_s][0]), "R5", "wake_tag", wake_tag, ptq[exp_s][0]);
      chk(wake_slot == SLW'(pqq[exp_s][0]), "R5", "wake_slot", wake_slot, pqq[exp_s][0]);
    end
    for (int r = 0; r < NPHYS; r++) exp_pin[r] = pcnt[r] != 0;
    chk(pinned == exp_pin, "R8", "pinned", pinned, exp_pin);
    if (d_rv) begin
      chk(rf_addr == TW'(d_rt), "R9", "rf_addr", rf_addr, d_rt);
      chk(rd_data == rfval(d_rt), "R9", "rd_data", rd_data, rfval(d_rt));
      chk(pinned[d_rt] == 1'b1, "R10", "read target pinned", pinned[d_rt], 1);
    end
    @(posedge clk);
    if (exp_v && d_wr) begin
      pcnt[ptq[exp_s][0]]++;
      rdq.push_back(ptq[exp_s][0]);
      void'(ptq[exp_s].pop_front());
      void'(pqq[exp_s].pop_front());
    end
    lk = exp_v && !d_wr;
    lk_s = exp_s;
    if (d_pv && exp_pr) begin ptq[d_ps].push_back(d_pt); pushed[d_ps]++; end
    if (d_ov && exp_or) begin pqq[d_os].push_back(d_oslot); popped[d_os]++; end
    if (d_rv) pcnt[d_rt]--;
  endtask

  task automatic idle();
    d_pv = 0; d_ov = 0; d_wr = 0; d_rv = 0;
    d_ps = 0; d_pt = 0; d_os = 0; d_oslot = 0; d_rt = 0;
  endtask

  task automatic pick_read();
    d_rv = 0;
    if (rdq.size() > 0 && (rdq.size() >= 3 || $urandom % 3 == 0)) begin
      d_rv = 1;
      d_rt = rdq.pop_front();
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1: reset state
    chk(wake_valid == 0, "R1", "wake_valid", wake_valid, 0);
    chk(pinned == 0, "R1", "pinned", pinned, 0);
    chk(push_ready == 1, "R1", "push_ready", push_ready, 1);
    chk(pop_ready == 1, "R1", "pop_ready", pop_ready, 1);

    // R4: send then receive, source not yet computed
    idle(); d_pv = 1; d_ps = 1; d_pt = 7; step();
    idle(); d_ov = 1; d_os = 1; d_oslot = 3; d_wr = 1; step();
    idle(); d_wr = 1; step(); step();
    mask[7] = 1;
    idle(); d_wr = 1; step();
    idle(); step();
    // R10, R9: read the handed-over tag
    idle(); d_rv = 1; d_rt = rdq.pop_front(); step();
    idle(); step();

    // R2, R3: fill section 2 queues, check ready drop
    for (int i = 0; i < DEPTH + 1; i++) begin idle(); d_pv = 1; d_ps = 2; d_pt = 20 + i; step(); end
    for (int i = 0; i < DEPTH + 1; i++) begin idle(); d_ov = 1; d_os = 2; d_oslot = i; step(); end

    // R7, R6: stall section 3, then make section 0 eligible
    idle(); d_pv = 1; d_ps = 3; d_pt = 9; step();
    idle(); d_ov = 1; d_os = 3; d_oslot = 5; mask[9] = 1; step();
    idle(); d_pv = 1; d_ps = 0; d_pt = 9; step();
    idle(); d_ov = 1; d_os = 0; d_oslot = 6; step();
    idle(); step(); step();
    mask = '1;
    for (int i = 0; i < 20; i++) begin idle(); d_wr = 1; pick_read(); step(); end
    while (rdq.size() > 0) begin idle(); d_rv = 1; d_rt = rdq.pop_front(); step(); end
    mask = '0;

    // Random traffic with periodic drains
    for (int blk = 0; blk < 6; blk++) begin
      for (int c = 0; c < 500; c++) begin
        idle();
        if ($urandom % 6 == 0) mask[$urandom % NPHYS] = 1'b1;
        d_pv = ($urandom % 2) == 0; d_ps = $urandom % NS; d_pt = $urandom % NPHYS;
        d_os = $urandom % NS; d_oslot = $urandom % 16;
        d_ov = (pushed[d_os] > popped[d_os]) && ($urandom % 2 == 0);
        d_wr = ($urandom % 4) != 0;
        pick_read();
        step();
      end
      mask = '1;
      for (int c = 0; c < 60; c++) begin
        idle();
        d_wr = 1;
        for (int s = 0; s < NS; s++) if (pushed[s] > popped[s]) begin d_os = s; d_ov = 1; end
        d_oslot = c % 16;
        pick_read();
        step();
      end
      while (rdq.size() > 0) begin idle(); d_wr = 1; d_rv = 1; d_rt = rdq.pop_front(); step(); end
      mask = '0;
      for (int s = 0; s < NS; s++) if (ptq[s].size() > 0) mask = '1;
    end
    idle(); step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule